// File: doc/BRIEF.md
# Ring-Chained FIFO Depth Slice

This block is one slice of a FIFO that grows in depth by chaining identical slices in a ring. Every slice in the ring sees the same write data, write enable, read enable and reset. Two tokens decide which slice acts on those shared lines. The write token names the slice that stores the next word. The read token names the slice that returns the next word. No address bus and no central controller are involved: a slice passes a token to its ring neighbour as a pulse on its expansion output, and that output is wired to the neighbour's expansion input.

The first-load input picks the slice that holds both tokens when reset ends. Each slice keeps its own ring pointers, its own occupancy count and its own active-low empty and full flags. Read data from a slice is zero except in the cycle where it returns a word, so the outputs of the chain merge with a plain OR and need no tri-state bus. The composite chain flags are the OR of the active-low slice flags, so the chain reports empty or full only when every slice does.

Top module: `chainFifoSlice`

## Requirements
- R1: While `rstN` is low at a clock edge, the slice clears its pointers and count and sets `emptyN` low, `fullN` high, `rdValid` low and `expandOut` low. The slice whose `firstLoadN` is low takes both tokens. Every other slice takes neither token.
- R2: A write is accepted at a clock edge only when `wrEn` is high, the slice owns the write token and the slice is not full. Accepted words are stored at successive locations of the slice.
- R3: A read is accepted at a clock edge only when `rdEn` is high, the slice owns the read token and the slice is not empty. The oldest word in the slice appears on `rdData` with `rdValid` high for the one cycle after that edge. In every other cycle `rdData` is all zeros.
- R4: A write to location DEPTH-1 of the slice gives up the write token. `expandOut` is high in the cycle after that edge.
- R5: A read from location DEPTH-1 of the slice gives up the read token. `expandOut` is high in the cycle after that edge.
- R6: Each cycle in which `expandIn` is high delivers one token. The deliveries alternate: the first after reset is the write token, the next is the read token, and so on. A delivered token can be used in the same cycle as its pulse, so a handoff costs no idle cycle.
- R7: A write offered while the write-token owner is full is dropped and changes no state. A read offered while the read-token owner is empty returns nothing.
- R8: `emptyN` is low exactly when the slice holds no word. `fullN` is low exactly when the slice holds DEPTH words.
- R9: A ring of N slices with OR-merged outputs behaves as one FIFO of N*DEPTH words. Words come out in write order. At most one slice raises `rdValid` in any cycle. The OR of all `emptyN` is low exactly when the chain is empty, and the OR of all `fullN` is low exactly when the chain is full.
- R10: A read and a write offered at the same edge are both served when the FIFO state allows each one, judged on the state before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| firstLoadN | input | 1 | Low on the slice that owns both tokens after reset |
| expandIn | input | 1 | Token pulse from the previous slice in the ring |
| wrEn | input | 1 | Shared write request |
| wrData | input | WIDTH | Shared write data |
| rdEn | input | 1 | Shared read request |
| rdData | output | WIDTH | Word returned by this slice, zero when none is returned |
| rdValid | output | 1 | High for one cycle with each returned word |
| emptyN | output | 1 | Low when the slice is empty |
| fullN | output | 1 | Low when the slice is full |
| expandOut | output | 1 | Token pulse to the next slice in the ring |

## Verification
The assertions rely on four conditions. Exactly one slice in the ring has `firstLoadN` low. DEPTH is at least two. Every `expandIn` pulse comes from the ring neighbour, so an arriving token is never one the slice already holds. The shared enables change only outside the sampling edge. The bench meets these by closing a three-slice ring whose only first-load slice is slice 0, and by driving all shared inputs on the falling clock edge. Its streams of writes, reads and mixed traffic push both tokens past every slice boundary, including handoffs that happen back to back.

// File: rtl/chainFifoPkg.sv
package chainFifoPkg;

  // strobes from the token control to the storage datapath
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } strobe_t;

  // storage state reported back to the token control
  typedef struct packed {
    logic empty;
    logic full;
    logic wrAtLast;
    logic rdAtLast;
  } status_t;

endpackage

// File: rtl/chainRingPtr.sv
module chainRingPtr #(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          advance,
  output logic [PW-1:0] ptr,
  output logic          atLast
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  assign atLast = (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rstN)        ptr <= '0;
    else if (advance) ptr <= atLast ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/chainFifoData.sv
module chainFifoData
  import chainFifoPkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] wrData,
  output status_t          status,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic             wrLast, rdLast;
  logic [CW-1:0]    count;

  chainRingPtr #(.DEPTH(DEPTH)) u_wrPtr (
    .clk(clk), .rstN(rstN), .advance(strobe.wrFire), .ptr(wrPtr), .atLast(wrLast)
  );

  chainRingPtr #(.DEPTH(DEPTH)) u_rdPtr (
    .clk(clk), .rstN(rstN), .advance(strobe.rdFire), .ptr(rdPtr), .atLast(rdLast)
  );

  always_comb begin
    status.empty    = (count == '0);
    status.full     = (count == CAP);
    status.wrAtLast = wrLast;
    status.rdAtLast = rdLast;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrFire) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({strobe.wrFire, strobe.rdFire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= strobe.rdFire ? mem[rdPtr] : '0;
      rdValid <= strobe.rdFire;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    status.full |-> !strobe.wrFire);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    status.empty |-> !strobe.rdFire);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CAP);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (count == '0 && !rdValid && rdData == '0));

  assert_ptrs_meet_when_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    status.empty |-> (wrPtr == rdPtr));

endmodule

// File: rtl/chainFifoCtrl.sv
module chainFifoCtrl
  import chainFifoPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    firstLoadN,
  input  logic    expandIn,
  input  logic    wrEn,
  input  logic    rdEn,
  input  status_t status,
  output strobe_t strobe,
  output logic    expandOut
);

  logic wrOwn, rdOwn;
  logic passRead;      // kind of the next token to arrive: 0 write, 1 read
  logic takeWr, takeRd;
  logic wrPass, rdPass;

  always_comb begin
    takeWr        = expandIn & ~passRead;
    takeRd        = expandIn &  passRead;
    strobe.wrFire = wrEn & (wrOwn | takeWr) & ~status.full;
    strobe.rdFire = rdEn & (rdOwn | takeRd) & ~status.empty;
    wrPass        = strobe.wrFire & status.wrAtLast;
    rdPass        = strobe.rdFire & status.rdAtLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrOwn     <= ~firstLoadN;
      rdOwn     <= ~firstLoadN;
      passRead  <= 1'b0;
      expandOut <= 1'b0;
    end else begin
      if (wrPass)      wrOwn <= 1'b0;
      else if (takeWr) wrOwn <= 1'b1;
      if (rdPass)      rdOwn <= 1'b0;
      else if (takeRd) rdOwn <= 1'b1;
      if (expandIn)    passRead <= ~passRead;
      expandOut <= wrPass | rdPass;
    end
  end

  assert_reset_tokens_R1: assert property (@(posedge clk)
    !rstN |=> (wrOwn == rdOwn && !expandOut));

  assert_write_token_new_R6: assert property (@(posedge clk) disable iff (!rstN)
    (expandIn && !passRead) |-> !wrOwn);

  assert_read_token_new_R6: assert property (@(posedge clk) disable iff (!rstN)
    (expandIn && passRead) |-> !rdOwn);

  assert_single_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPass && rdPass));

  assert_write_pass_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrOwn) |-> expandOut);

  assert_read_pass_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdOwn) |-> expandOut);

endmodule

// File: rtl/chainFifoSlice.sv
module chainFifoSlice
  import chainFifoPkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             firstLoadN,
  input  logic             expandIn,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             emptyN,
  output logic             fullN,
  output logic             expandOut
);

  strobe_t strobe;
  status_t status;

  chainFifoCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN), .expandIn(expandIn),
    .wrEn(wrEn), .rdEn(rdEn), .status(status), .strobe(strobe),
    .expandOut(expandOut)
  );

  chainFifoData #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .status(status), .rdData(rdData), .rdValid(rdValid)
  );

  assign emptyN = ~status.empty;
  assign fullN  = ~status.full;

  assert_valid_has_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(emptyN));

endmodule

// File: tb/test_chainFifoSlice.sv
module test_chainFifoSlice;

  localparam int WIDTH = 9;
  localparam int DEPTH = 4;
  localparam int NSL   = 3;
  localparam int CAP   = NSL * DEPTH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;

  logic [NSL-1:0] emptyNv, fullNv, validV, xo;
  logic [WIDTH-1:0] rdDataV [NSL];
  logic [WIDTH-1:0] chainData;
  logic chainValid, chainEmptyN, chainFullN;

  always #4 clk = ~clk;   // 125 MHz

  for (genvar k = 0; k < NSL; k++) begin : slot
    chainFifoSlice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_chainFifoSlice (
      .clk(clk), .rstN(rstN),
      .firstLoadN(k == 0 ? 1'b0 : 1'b1),
      .expandIn(xo[(k + NSL - 1) % NSL]),
      .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
      .rdData(rdDataV[k]), .rdValid(validV[k]),
      .emptyN(emptyNv[k]), .fullN(fullNv[k]), .expandOut(xo[k])
    );
  end

  always_comb begin
    chainData = '0;
    for (int k = 0; k < NSL; k++) chainData = chainData | rdDataV[k];
    chainValid  = |validV;
    chainEmptyN = |emptyNv;
    chainFullN  = |fullNv;
  end

  int checks = 0, fails = 0;
  bit running = 1'b0, done = 1'b0;
  logic [WIDTH-1:0] model [$];
  logic [WIDTH-1:0] outQ [$];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: called at a falling edge, applies one cycle of stimulus
  task automatic step(input bit wr, input logic [WIDTH-1:0] d, input bit rd);
    int pre = model.size();
    wrEn = wr; wrData = d; rdEn = rd;
    if (rd && pre > 0) outQ.push_back(model.pop_front());   // R10 judged on pre-edge state
    if (wr && pre < CAP) model.push_back(d);                // R7 drop when full
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R9 chain empty flag", chainEmptyN, model.size() != 0);
    check("R9 chain full flag", chainFullN, model.size() != CAP);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      check("R9 one reader per cycle", $countones(validV) <= 1, 1);
      if (chainValid) begin
        if (outQ.size() == 0) check("R7 unexpected read data", 1, 0);
        else check("R3 R9 read data order", chainData, outQ.pop_front());
      end else begin
        check("R3 idle data zero", chainData, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 emptyN low", emptyNv, 0);
    check("R1 fullN high", fullNv, {NSL{1'b1}});
    check("R1 no valid", validV, 0);
    check("R1 no pulse", xo, 0);
    rstN = 1'b1;
    running = 1'b1;

    // R2 R4 fill slice 0; token passes on its last location
    for (int i = 0; i < DEPTH; i++) step(1'b1, WIDTH'(9'h101 + i), 1'b0);
    check("R4 expandOut after last write", xo[0], 1);
    check("R8 slice0 full", fullNv[0], 0);
    check("R2 slice1 untouched", emptyNv[1], 0);
    // R6 next slice takes the write in the handoff cycle
    step(1'b1, 9'h1F0, 1'b0);
    check("R6 slice1 written in handoff cycle", emptyNv[1], 1);
    check("R4 pulse one cycle", xo[0], 0);
    for (int i = 0; i < CAP - DEPTH - 1; i++) step(1'b1, WIDTH'(9'h0A0 + i), 1'b0);
    check("R9 all full", fullNv, 0);
    // R7 ignored write while full
    step(1'b1, 9'h1AA, 1'b0);
    check("R7 still full", chainFullN, 0);

    // R5 drain slice 0; read token passes
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1);
    check("R5 expandOut after last read", xo[0], 1);
    check("R8 slice0 empty", emptyNv[0], 0);

    // R10 simultaneous reads and writes
    for (int i = 0; i < 20; i++) step(1'b1, WIDTH'(9'h040 + 3 * i), 1'b1);

    // drain then read from empty
    while (model.size() > 0) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    check("R7 chain empty", chainEmptyN, 0);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[WIDTH+2:3], lfsr[1]);
    end
    while (model.size() > 0) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    check("R3 every accepted read returned", outQ.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule